// File: doc/BRIEF.md
# Per-Lane Variable Vector Shifter

This block takes a data vector and a count vector of the same width, splits both into lanes of 8, 16, 32 or 64 bits, and shifts every data lane by a signed amount held in the lowest byte of the matching count lane. A positive amount moves the lane towards its top; a negative amount moves it towards its bottom by the magnitude. The lanes are treated as signed or unsigned, and two optional controls apply. One rounds right shifts to nearest instead of truncating. The other clamps left shifts that overflow the lane to the lane's limits. A sticky flag records any clamp until software-side logic clears it with a pulse.

Operands and controls enter on a valid/ready stream and results leave on a second valid/ready stream through one register stage. An operation is taken on a rising edge where `in_valid` and `in_ready` are both high. Its result is presented on the following cycle. The result stays on `out_data` with `out_valid` high until a cycle in which `out_ready` is high. `in_ready` is high whenever the output register is empty or is being emptied in the same cycle, so the stage sustains one operation per cycle with `out_ready` held high. When `out_ready` is low and a result is waiting, back-pressure reaches the input in the same cycle. A 64-bit operation uses only the lower half of both operand vectors.

Top module: `vshift_top`

## Requirements
- R1: The shift amount of a lane is bits [7:0] of the matching count lane, read as two's complement; the remaining count bits of that lane have no effect. A positive amount shifts left, filling with zeros; with clamping disabled, bits moved beyond the lane's top are lost, and an amount at or above the lane width gives zero.
- R2: An amount of zero returns the data lane unchanged, for every mode.
- R3: A negative amount -m shifts right by m: arithmetic (sign-filled) for signed lanes, logical (zero-filled) for unsigned lanes, truncating toward minus infinity when rounding is off.
- R4: With rounding off, a right shift by m at or above the lane width gives all ones for a negative signed lane and zero for any other lane.
- R5: With rounding on, a right shift by m gives floor((x + 2^(m-1)) / 2^m) of the lane value x, evaluated with enough width that the sum never wraps; for m beyond the lane width this is zero.
- R6: With clamping on, a left shift whose exact result lies outside the lane range gives the lane maximum (signed 2^(W-1)-1, unsigned 2^W-1) for overflow upward and the signed minimum -2^(W-1) for overflow downward.
- R7: `sat_sticky` becomes 1 after a rising edge that accepts an operation in which any active lane clamped; it returns to 0 only after an edge with `sat_clr` high and no clamping operation accepted on that same edge (setting wins).
- R8: `in_esize` picks the lane width: 0 = 8, 1 = 16, 2 = 32, 3 = 64 bits.
- R9: With `in_wide` low, only lanes within bits [63:0] are active; bits [127:64] of the result are zero and lanes there never contribute to `sat_sticky`.
- R10: A result appears on the cycle after acceptance, stays unchanged with `out_valid` high while `out_ready` is low, and `in_ready` equals `!out_valid || out_ready`.
- R11: After reset `out_valid` and `sat_sticky` are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| in_data | input | 128 | Data vector |
| in_cnt | input | 128 | Count vector, amount in the low byte of each lane |
| in_esize | input | 2 | Lane width code (R8) |
| in_signed | input | 1 | Lanes are two's complement |
| in_round | input | 1 | Round right shifts to nearest |
| in_sat | input | 1 | Clamp overflowing left shifts |
| in_wide | input | 1 | 1 = 128-bit vector, 0 = 64-bit vector |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | 128 | Shifted vector |
| sat_clr | input | 1 | Clear the sticky clamp flag |
| sat_sticky | output | 1 | A clamp has happened since the last clear |

## Verification
On every cycle the assertions watch the stream rules (a held result stays put, an accepted operation yields a valid result, a narrow operation leaves the upper half zero), the hold and clear behaviour of the sticky flag, and in each lane that a clamped result is exactly a range limit and that an unsigned truncating right shift never grows the value. Whether each lane carries the right number, across widths, signedness, rounding, amounts past the lane width and the ignored count bits, can only be shown by the bench's scenarios, which compare every result against a wide-arithmetic model built from the requirements.

// File: rtl/vshift_pkg.sv
package vshift_pkg;

  // Lane width codes; the value is log2(width / 8).
  typedef enum logic [1:0] {
    ESZ_8  = 2'd0,
    ESZ_16 = 2'd1,
    ESZ_32 = 2'd2,
    ESZ_64 = 2'd3
  } esize_e;

  localparam int NUM_SIZES = 4;
  localparam int BASE_LANE = 8;
  localparam int CNT_BITS  = 8;

endpackage

// File: rtl/vshift_lane.sv
module vshift_lane #(
  parameter int LW = 8
) (
  input  logic [LW-1:0] a,
  input  logic [7:0]    cnt_b,
  input  logic          sgn,
  input  logic          rnd,
  input  logic          sat,
  output logic [LW-1:0] res,
  output logic          hit
);

  localparam int        IW  = $clog2(LW);
  localparam logic [7:0] LWB = 8'(LW);

  logic          is_zero;
  logic          is_right;
  logic [7:0]    lsh;
  logic [7:0]    rsh;
  logic [7:0]    rm1;
  logic          fill;
  logic [LW-1:0] lres;
  logic [LW-1:0] back;
  logic          lovf;
  logic [LW-1:0] hi_lim;
  logic [LW-1:0] lo_lim;
  logic [LW-1:0] clamp;
  logic [LW-1:0] trunc;
  logic          rbit;
  logic [LW-1:0] rres;

  assign is_zero  = (cnt_b == 8'd0);
  assign is_right = cnt_b[7];
  assign lsh      = cnt_b;
  assign rsh      = 8'd0 - cnt_b;
  assign rm1      = rsh - 8'd1;
  assign fill     = sgn & a[LW-1];

  // Range limits of the lane.
  assign hi_lim = sgn ? {1'b0, {(LW-1){1'b1}}} : {LW{1'b1}};
  assign lo_lim = sgn ? {1'b1, {(LW-1){1'b0}}} : {LW{1'b0}};
  assign clamp  = fill ? lo_lim : hi_lim;

  // Left path: shift, then undo the shift to detect lost information.
  always_comb begin
    if (lsh >= LWB) begin
      lres = '0;
      back = '0;
      lovf = (a != '0);
    end else begin
      lres = a << lsh;
      back = sgn ? LW'($signed(lres) >>> lsh) : (lres >> lsh);
      lovf = (back != a);
    end
  end

  // Right path: truncated quotient plus the last bit shifted out.
  always_comb begin
    if (rsh >= LWB) trunc = {LW{fill}};
    else if (sgn)   trunc = LW'($signed(a) >>> rsh);
    else            trunc = a >> rsh;
    if (rsh > LWB)  rbit = fill;
    else            rbit = a[rm1[IW-1:0]];
    rres = trunc + {{(LW-1){1'b0}}, rnd & rbit};
  end

  always_comb begin
    if (is_zero)          res = a;
    else if (is_right)    res = rres;
    else if (sat && lovf) res = clamp;
    else                  res = lres;
  end

  assign hit = !is_zero && !is_right && sat && lovf;

  always_comb begin
    if (hit) begin
      // R6
      clamp_value_chk: assert (res == hi_lim || res == lo_lim);
    end
    if (is_right && !sgn && !rnd) begin
      // R3
      right_shrink_chk: assert (res <= a);
    end
  end

endmodule

// File: rtl/vshift_array.sv
module vshift_array #(
  parameter int VEC_W = 128,
  parameter int LW    = 8
) (
  input  logic [VEC_W-1:0] a_vec,
  input  logic [VEC_W-1:0] c_vec,
  input  logic             sgn,
  input  logic             rnd,
  input  logic             sat,
  input  logic             wide,
  output logic [VEC_W-1:0] r_vec,
  output logic             any_hit
);

  localparam int NL   = VEC_W / LW;
  localparam int HALF = NL / 2;

  logic [NL-1:0] hits;

  for (genvar i = 0; i < NL; i++) begin : g_lane
    localparam bit LOWER = (i < HALF);
    logic [LW-1:0] lr;
    logic          lh;
    logic          live;

    assign live = wide | LOWER;

    vshift_lane #(.LW(LW)) u_lane (
      .a     (a_vec[i*LW +: LW]),
      .cnt_b (c_vec[i*LW +: 8]),
      .sgn   (sgn),
      .rnd   (rnd),
      .sat   (sat),
      .res   (lr),
      .hit   (lh)
    );

    assign r_vec[i*LW +: LW] = live ? lr : '0;
    assign hits[i]           = live & lh;
  end

  assign any_hit = |hits;

endmodule

// File: rtl/vshift_top.sv
module vshift_top
  import vshift_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [VEC_W-1:0] in_data,
  input  logic [VEC_W-1:0] in_cnt,
  input  logic [1:0]       in_esize,
  input  logic             in_signed,
  input  logic             in_round,
  input  logic             in_sat,
  input  logic             in_wide,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [VEC_W-1:0] out_data,
  input  logic             sat_clr,
  output logic             sat_sticky
);

  localparam int HALF_W = VEC_W / 2;

  logic [NUM_SIZES-1:0][VEC_W-1:0] sres;
  logic [NUM_SIZES-1:0]            shit;
  logic [VEC_W-1:0]                sel_res;
  logic                            sel_hit;
  logic                            accept;
  esize_e                          esz;

  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_size
    vshift_array #(.VEC_W(VEC_W), .LW(BASE_LANE << g)) u_arr (
      .a_vec   (in_data),
      .c_vec   (in_cnt),
      .sgn     (in_signed),
      .rnd     (in_round),
      .sat     (in_sat),
      .wide    (in_wide),
      .r_vec   (sres[g]),
      .any_hit (shit[g])
    );
  end

  assign esz = esize_e'(in_esize);

  always_comb begin
    unique case (esz)
      ESZ_8:   begin sel_res = sres[0]; sel_hit = shit[0]; end
      ESZ_16:  begin sel_res = sres[1]; sel_hit = shit[1]; end
      ESZ_32:  begin sel_res = sres[2]; sel_hit = shit[2]; end
      default: begin sel_res = sres[3]; sel_hit = shit[3]; end
    endcase
  end

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_data   <= '0;
      sat_sticky <= 1'b0;
    end else begin
      if (accept) begin
        out_valid <= 1'b1;
        out_data  <= sel_res;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
      sat_sticky <= (sat_sticky && !sat_clr) || (accept && sel_hit);
    end
  end

  // R10
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R10
  take_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R9
  half_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !in_wide |=> out_data[VEC_W-1:HALF_W] == '0);

  // R7
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sat_sticky && !sat_clr |=> sat_sticky);

  // R7
  sticky_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sat_clr && !(in_valid && in_ready) |=> !sat_sticky);

endmodule

// File: tb/test_vshift_top.sv
module test_vshift_top;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] in_data = '0;
  logic [127:0] in_cnt = '0;
  logic [1:0]   in_esize = '0;
  logic         in_signed = 1'b0;
  logic         in_round = 1'b0;
  logic         in_sat = 1'b0;
  logic         in_wide = 1'b1;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [127:0] out_data;
  logic         sat_clr = 1'b0;
  logic         sat_sticky;

  always #5 clk = ~clk;

  vshift_top i_vshift_top (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_cnt(in_cnt), .in_esize(in_esize),
    .in_signed(in_signed), .in_round(in_round), .in_sat(in_sat),
    .in_wide(in_wide), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .sat_clr(sat_clr), .sat_sticky(sat_sticky)
  );

  typedef struct {
    logic [127:0] d;
    string        tag;
  } exp_t;

  exp_t  exp_q[$];
  int    checks = 0;
  int    fails = 0;
  logic  exp_sticky = 1'b0;
  int    bp_mode = 0;
  logic [31:0] seed = 32'h1234_5678;
  logic [31:0] bp_seed = 32'hCAFE_0001;

  function automatic logic [31:0] step(input logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]} ^ 32'h9E37_79B9 * (s[3:0] + 1);
  endfunction

  task automatic check(input bit ok, input string req, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Reference lane: wide two's complement arithmetic from the requirements.
  function automatic logic [63:0] ref_lane(input logic [63:0] a, input logic [7:0] cb,
      input int w, input bit sgn, input bit rnd, input bit sat, output bit hit);
    logic signed [199:0] v, full, one, mx, mn, addv;
    int c, m;
    one = 1;
    for (int b = 0; b < 200; b++) v[b] = (b < w) ? a[b] : (sgn & a[w-1]);
    c = int'($signed(cb));
    hit = 0;
    if (c == 0) begin
      full = v;
    end else if (c > 0) begin
      full = v <<< c;
      mx = (one <<< (sgn ? w - 1 : w)) - one;
      mn = sgn ? -(one <<< (w - 1)) : '0;
      if (sat && full > mx) begin full = mx; hit = 1; end
      else if (sat && full < mn) begin full = mn; hit = 1; end
    end else begin
      m = -c;
      addv = rnd ? (one <<< (m - 1)) : '0;
      full = (v + addv) >>> m;
    end
    ref_lane = '0;
    for (int b = 0; b < w; b++) ref_lane[b] = full[b];
  endfunction

  function automatic logic [127:0] ref_vec(input logic [127:0] d, input logic [127:0] c,
      input logic [1:0] esz, input bit sgn, input bit rnd, input bit sat, input bit wide,
      output bit any);
    int w, nl, act;
    logic [63:0] a, r;
    bit h;
    w = 8 << esz;
    nl = 128 / w;
    act = wide ? nl : nl / 2;
    any = 0;
    ref_vec = '0;
    for (int l = 0; l < act; l++) begin
      a = '0;
      for (int b = 0; b < w; b++) a[b] = d[l*w + b];
      r = ref_lane(a, c[l*w +: 8], w, sgn, rnd, sat, h);
      any |= h;
      for (int b = 0; b < w; b++) ref_vec[l*w + b] = r[b];
    end
  endfunction

  task automatic send(input logic [127:0] d, input logic [127:0] c, input logic [1:0] esz,
      input bit sgn, input bit rnd, input bit sat, input bit wide, input string tag);
    exp_t e;
    bit h;
    e.d = ref_vec(d, c, esz, sgn, rnd, sat, wide, h);
    e.tag = tag;
    @(negedge clk);
    in_data = d; in_cnt = c; in_esize = esz; in_signed = sgn;
    in_round = rnd; in_sat = sat; in_wide = wide; in_valid = 1'b1;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      #1;
    end
    exp_q.push_back(e);
    if (h) exp_sticky = 1'b1;
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // Back-pressure: 0 = always ready, 1 = pseudo-random, 2 = held low.
  initial forever begin
    @(posedge clk);
    #2;
    bp_seed = step(bp_seed);
    if (bp_mode == 0)      out_ready = 1'b1;
    else if (bp_mode == 1) out_ready = bp_seed[5] | bp_seed[9];
    else                   out_ready = 1'b0;
  end

  // Monitor: compare each transferred result with the scoreboard head.
  initial forever begin
    @(negedge clk);
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R10 unexpected result", out_data, '0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(out_data === e.d, e.tag, out_data, e.d);
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  function automatic logic [127:0] shaped_counts(input logic [1:0] esz);
    int w;
    logic [127:0] c;
    w = 8 << esz;
    for (int k = 0; k < 4; k++) begin
      seed = step(seed);
      c[k*32 +: 32] = seed;
    end
    for (int l = 0; l < 128 / w; l++) begin
      seed = step(seed);
      if (seed[1:0] != 2'b00)
        c[l*w +: 8] = 8'(int'(seed[15:4] % (2*w + 5)) - (w + 2));
    end
    return c;
  endfunction

  initial begin
    logic [127:0] held;
    logic [127:0] d, c;
    // R11: reset state
    repeat (3) @(negedge clk);
    check(out_valid === 1'b0, "R11 out_valid", {127'd0, out_valid}, '0);
    check(sat_sticky === 1'b0, "R11 sat_sticky", {127'd0, sat_sticky}, '0);
    check(in_ready === 1'b1, "R11 in_ready", {127'd0, in_ready}, 128'd1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 R2 R3 R4 R8: byte lanes, mixed amounts including 0, +/-8, -9, -128, +127
    d = 128'h80_7F_01_FF_40_C0_11_EE_55_AA_93_6C_08_F0_3C_C3;
    c = 128'h01_FF_00_07_F8_F7_08_80_7F_02_FE_FD_03_00_F9_04;
    send(d, c, 2'd0, 1, 0, 0, 1, "R1 R2 R3 R4 signed bytes");
    send(d, c, 2'd0, 0, 0, 0, 1, "R3 R4 unsigned bytes");
    // R5: rounding, signed and unsigned
    send(d, c, 2'd0, 1, 1, 0, 1, "R5 signed rounding");
    send(d, c, 2'd0, 0, 1, 0, 1, "R5 unsigned rounding");
    // R6: clamping
    send(d, c, 2'd0, 1, 0, 1, 1, "R6 signed clamp");
    send(d, c, 2'd0, 0, 0, 1, 1, "R6 unsigned clamp");
    // R1: upper count bits vary, only the low byte of each lane counts
    c = 128'hDEAD_BEEF_1234_00FD_FFFF_FF03_A5A5_5A81;
    send(d, c, 2'd1, 1, 0, 1, 1, "R1 R8 16-bit lanes ignore upper count bits");
    c = 128'h0000_0000_0000_0000_FFFF_FFFF_FFFF_FF03;
    send(d, c, 2'd1, 1, 0, 1, 1, "R1 R8 16-bit lanes");
    c = 128'h1111_11E0_2222_2221_3333_33C0_4444_441F;
    send(d, c, 2'd2, 1, 1, 0, 1, "R4 R5 R8 32-bit lanes");
    c = 128'h0000_0000_0000_00C0_0000_0000_0000_0041;
    send(d, c, 2'd3, 0, 1, 1, 1, "R4 R5 R6 R8 64-bit lanes");
    // R9: narrow vector, upper lanes would clamp but must not count
    drain();
    sat_clr = 1'b1; @(posedge clk); #1 sat_clr = 1'b0; exp_sticky = 1'b0;
    d = {64'h7FFF_7FFF_7FFF_7FFF, 64'h0001_0002_0003_0004};
    c = {64'h0010_0010_0010_0010, 64'h0001_0001_0001_0001};
    send(d, c, 2'd1, 1, 0, 1, 0, "R9 narrow vector");
    drain();
    check(sat_sticky === 1'b0, "R9 R7 no clamp in upper half", {127'd0, sat_sticky}, '0);
    // R7: clamp sets the flag, clear drops it
    send(d, c, 2'd1, 1, 0, 1, 1, "R6 R7 clamp in upper half");
    drain();
    check(sat_sticky === 1'b1, "R7 sticky set", {127'd0, sat_sticky}, 128'd1);
    send(d, 128'd0, 2'd0, 1, 0, 1, 1, "R2 zero amounts");
    drain();
    check(sat_sticky === 1'b1, "R7 sticky holds", {127'd0, sat_sticky}, 128'd1);
    @(negedge clk); sat_clr = 1'b1; @(posedge clk); #1 sat_clr = 1'b0;
    @(negedge clk);
    check(sat_sticky === 1'b0, "R7 sticky cleared", {127'd0, sat_sticky}, '0);
    exp_sticky = 1'b0;

    // R10: stall holds the result and blocks the input
    bp_mode = 2;
    repeat (2) @(negedge clk);
    send(d, c, 2'd0, 0, 0, 0, 1, "R10 stalled result");
    @(negedge clk);
    held = out_data;
    check(out_valid === 1'b1, "R10 valid during stall", {127'd0, out_valid}, 128'd1);
    check(in_ready === 1'b0, "R10 in_ready low during stall", {127'd0, in_ready}, '0);
    repeat (3) @(negedge clk);
    check(out_data === held, "R10 data stable during stall", out_data, held);
    bp_mode = 0;
    drain();

    // Pseudo-random mix with random back-pressure
    bp_mode = 1;
    for (int n = 0; n < 300; n++) begin
      logic [1:0] esz;
      seed = step(seed);
      esz = seed[1:0];
      for (int k = 0; k < 4; k++) begin
        seed = step(seed);
        d[k*32 +: 32] = seed;
      end
      c = shaped_counts(esz);
      seed = step(seed);
      send(d, c, esz, seed[2], seed[3], seed[4], seed[5] | seed[6],
           "R1 R3 R4 R5 R6 R8 R9 mixed");
    end
    bp_mode = 0;
    drain();
    check(sat_sticky === exp_sticky, "R7 sticky after mix",
          {127'd0, sat_sticky}, {127'd0, exp_sticky});
    check(exp_q.size() == 0, "R10 all results delivered", 128'(exp_q.size()), '0);
    summary();
  end

endmodule